// File: doc/BRIEF.md
# Pipelined Address Tenure Tracker

This block follows transactions on a split bus whose address and data phases proceed independently. Every address tenure is entered into a per-tag slot when it starts. Once its address phase ends, the slot waits for the matching data tenure. New address tenures may therefore be issued while earlier data tenures are still outstanding.

The block limits pipelining depth. Only a fixed number of data-carrying tenures (three by default) may wait for their data tenure at once, and `issue_en` drops while that limit is reached. Transactions that move no data are exempt from the limit. A retry termination on the address phase cancels the tenure at once, so the same tag can be issued again later.

Data tenures carry the tag of the transaction they serve and may complete in any order. Each completion is reported with its tag. Events that match no suitable slot raise a one-cycle error pulse and change no state.

Top module: `tenure_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pend_cnt` is 0, `issue_en` is 1, and `done_valid` and `tag_err` are 0.
- R2: `pend_cnt` counts data-carrying tenures from an accepted `as_valid` until their data tenure starts (`ds_valid`) or they are retried. It never exceeds MAX_PEND (3), and `issue_en` is 1 exactly when `pend_cnt` is below MAX_PEND.
- R3: A start with `as_addr_only`=1 is accepted even when `issue_en` is 0 and never changes `pend_cnt`. A non-retry end (`ae_valid`, `ae_retry`=0) frees its tag.
- R4: A data tenure start that lowers `pend_cnt` from MAX_PEND makes `issue_en` 1 in the next cycle.
- R5: `dd_valid` on a tag whose data tenure has started gives `done_valid`=1 with `done_tag` equal to that tag one cycle later. Completions may follow any order relative to issue order.
- R6: An address end with `ae_retry`=1 frees the slot in the cycle it is seen. `pend_cnt` drops at the next edge, and the tag can be started again.
- R7: An accepted data-carrying start and a data tenure start in the same cycle leave `pend_cnt` unchanged.
- R8: `ds_valid` on a tag not waiting for data, `dd_valid` on a tag with no data tenure in progress, or `ae_valid` on a tag without an open address phase gives `tag_err`=1 one cycle later. None of these changes `pend_cnt` or `done_valid`.
- R9: A data-carrying start while `issue_en` is 0, or any start on a busy tag, is ignored. `pend_cnt` does not change, and `tag_err` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_valid | input | 1 | Address tenure start |
| as_tag | input | TAG_W | Tag of the starting tenure |
| as_addr_only | input | 1 | Starting tenure carries no data |
| ae_valid | input | 1 | Address tenure end |
| ae_tag | input | TAG_W | Tag of the ending tenure |
| ae_retry | input | 1 | End is a retry termination |
| ds_valid | input | 1 | Data tenure start |
| ds_tag | input | TAG_W | Tag served by the data tenure |
| dd_valid | input | 1 | Data tenure completion |
| dd_tag | input | TAG_W | Tag of the completing data tenure |
| issue_en | output | 1 | A data-carrying address tenure may start |
| pend_cnt | output | CNT_W | Data-carrying tenures waiting for data |
| done_valid | output | 1 | A transaction completed last cycle |
| done_tag | output | TAG_W | Tag of the completed transaction |
| tag_err | output | 1 | An event last cycle matched no suitable slot |

## Verification
A slot stuck in the wrong state appears at the ports within one cycle of the next event on its tag. A completion then goes missing or arrives with the wrong tag, or `tag_err` pulses when it should not. A count that drifts from the slot contents shows up at once on `pend_cnt` and, at the limit, as `issue_en` held in the wrong value. The bench therefore reads the count and the error pulse after every event and compares each completion against a queue of expected tags.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,  // no transaction on this tag
    SL_ADDR = 2'd1,  // address phase open
    SL_WAIT = 2'd2,  // address done, waiting for data tenure
    SL_DATA = 2'd3   // data tenure in progress
  } slot_st_e;
endpackage

// File: rtl/tt_slot.sv
module tt_slot
  import tt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     alloc_i,
  input  logic     alloc_ao_i,
  input  logic     aend_i,
  input  logic     retry_i,
  input  logic     dstart_i,
  input  logic     ddone_i,
  output slot_st_e st_o,
  output logic     ao_o
);
  slot_st_e st_q, st_d;
  logic     ao_q;
  logic     st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SL_FREE: if (alloc_i)  st_d = SL_ADDR;
      SL_ADDR: if (aend_i)   st_d = (retry_i || ao_q) ? SL_FREE : SL_WAIT;
      SL_WAIT: if (dstart_i) st_d = SL_DATA;
      SL_DATA: if (ddone_i)  st_d = SL_FREE;
      default:               st_d = SL_FREE;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SL_FREE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ao_q <= 1'b0;
    end else if (alloc_i) begin
      ao_q <= alloc_ao_i;
    end
  end

  assign st_o = st_q;
  assign ao_o = ao_q;
endmodule

// File: rtl/tt_pend_cnt.sv
module tt_pend_cnt #(
  parameter int MAX_PEND = 3,
  localparam int CNT_W = $clog2(MAX_PEND + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_a_i,
  input  logic             dec_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             room_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PEND);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(inc_i) - CNT_W'(dec_a_i) - CNT_W'(dec_b_i);
    cnt_en = inc_i || dec_a_i || dec_b_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign room_o = (cnt_q < MAX_C);
endmodule

// File: rtl/tt_resp.sv
module tt_resp #(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [TAG_W-1:0] done_tag_i,
  input  logic             err_i,
  output logic             done_valid_o,
  output logic [TAG_W-1:0] done_tag_o,
  output logic             err_o
);
  logic             dv_q, err_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      dv_q  <= done_i;
      err_q <= err_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (done_i) begin
      tag_q <= done_tag_i;
    end
  end

  assign done_valid_o = dv_q;
  assign done_tag_o   = tag_q;
  assign err_o        = err_q;
endmodule

// File: rtl/tenure_tracker.sv
module tenure_tracker
  import tt_pkg::*;
#(
  parameter int TAG_W    = 3,
  parameter int MAX_PEND = 3,
  localparam int CNT_W   = $clog2(MAX_PEND + 1),
  localparam int NUM_TAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_valid,
  input  logic [TAG_W-1:0] as_tag,
  input  logic             as_addr_only,
  input  logic             ae_valid,
  input  logic [TAG_W-1:0] ae_tag,
  input  logic             ae_retry,
  input  logic             ds_valid,
  input  logic [TAG_W-1:0] ds_tag,
  input  logic             dd_valid,
  input  logic [TAG_W-1:0] dd_tag,
  output logic             issue_en,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             tag_err
);
  slot_st_e             st   [NUM_TAG];
  logic [NUM_TAG-1:0]   ao;
  logic [2*NUM_TAG-1:0] st_flat;
  logic                 room;
  logic                 as_ok, ae_hit, ds_hit, dd_hit;
  logic                 inc, dec_a, dec_b, err_d;

  always_comb begin
    as_ok  = as_valid && (st[as_tag] == SL_FREE) && (as_addr_only || room);
    ae_hit = ae_valid && (st[ae_tag] == SL_ADDR);
    ds_hit = ds_valid && (st[ds_tag] == SL_WAIT);
    dd_hit = dd_valid && (st[dd_tag] == SL_DATA);
    inc    = as_ok && !as_addr_only;
    dec_a  = ae_hit && ae_retry && !ao[ae_tag];
    dec_b  = ds_hit;
    err_d  = (as_valid && !as_ok) || (ae_valid && !ae_hit) ||
             (ds_valid && !ds_hit) || (dd_valid && !dd_hit);
  end

  for (genvar i = 0; i < NUM_TAG; i++) begin : g_slot
    tt_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (as_ok  && (as_tag == TAG_W'(i))),
      .alloc_ao_i (as_addr_only),
      .aend_i     (ae_hit && (ae_tag == TAG_W'(i))),
      .retry_i    (ae_retry),
      .dstart_i   (ds_hit && (ds_tag == TAG_W'(i))),
      .ddone_i    (dd_hit && (dd_tag == TAG_W'(i))),
      .st_o       (st[i]),
      .ao_o       (ao[i])
    );
    assign st_flat[2*i +: 2] = st[i];
  end

  tt_pend_cnt #(.MAX_PEND(MAX_PEND)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (inc),
    .dec_a_i (dec_a),
    .dec_b_i (dec_b),
    .cnt_o   (pend_cnt),
    .room_o  (room)
  );

  tt_resp #(.TAG_W(TAG_W)) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_i       (dd_hit),
    .done_tag_i   (dd_tag),
    .err_i        (err_d),
    .done_valid_o (done_valid),
    .done_tag_o   (done_tag),
    .err_o        (tag_err)
  );

  assign issue_en = room;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int TAG_W    = 3,
  parameter int MAX_PEND = 3,
  localparam int CNT_W   = $clog2(MAX_PEND + 1),
  localparam int NUM_TAG = 1 << TAG_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               as_valid,
  input logic [TAG_W-1:0]   as_tag,
  input logic               as_addr_only,
  input logic               ae_valid,
  input logic [TAG_W-1:0]   ae_tag,
  input logic               ae_retry,
  input logic               ds_valid,
  input logic [TAG_W-1:0]   ds_tag,
  input logic               dd_valid,
  input logic [TAG_W-1:0]   dd_tag,
  input logic               issue_en,
  input logic [CNT_W-1:0]   pend_cnt,
  input logic               done_valid,
  input logic [TAG_W-1:0]   done_tag,
  input logic               tag_err,
  input logic [2*NUM_TAG-1:0] st_flat,
  input logic [NUM_TAG-1:0] ao
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PEND);
  localparam logic [1:0] S_FREE = 2'd0, S_ADDR = 2'd1, S_WAIT = 2'd2, S_DATA = 2'd3;

  logic [1:0]       sa [NUM_TAG];
  logic [TAG_W:0]   pend_pop;

  always_comb begin
    pend_pop = '0;
    for (int i = 0; i < NUM_TAG; i++) begin
      sa[i] = st_flat[2*i +: 2];
      if ((sa[i] == S_WAIT) || ((sa[i] == S_ADDR) && !ao[i]))
        pend_pop = pend_pop + 1'b1;
    end
  end

  // R2
  a_r2_cap: assert property (@(posedge clk) disable iff (!rst_n) pend_cnt <= MAX_C);
  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    {{(TAG_W+1-CNT_W){1'b0}}, pend_cnt} == pend_pop);
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n) !issue_en |-> pend_cnt == MAX_C);
  // R5
  a_r5_done: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_valid && sa[dd_tag] == S_DATA) |=> (done_valid && done_tag == $past(dd_tag)));
  // R6
  a_r6_retry_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_valid && ae_retry && sa[ae_tag] == S_ADDR) |=> sa[$past(ae_tag)] == S_FREE);
  // R7
  a_r7_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (as_valid && !as_addr_only && issue_en && sa[as_tag] == S_FREE &&
     ds_valid && sa[ds_tag] == S_WAIT && !(ae_valid && ae_retry)) |=> $stable(pend_cnt));
  // R8
  a_r8_bad_ds: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && sa[ds_tag] != S_WAIT) |=> tag_err);
  a_r8_bad_dd: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_valid && sa[dd_tag] != S_DATA) |=> tag_err);
  // R9
  a_r9_full: assert property (@(posedge clk) disable iff (!rst_n)
    (as_valid && !as_addr_only && !issue_en) |=> (tag_err && pend_cnt <= $past(pend_cnt)));
endmodule

bind tenure_tracker tt_checker #(.TAG_W(TAG_W), .MAX_PEND(MAX_PEND)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .as_valid(as_valid), .as_tag(as_tag), .as_addr_only(as_addr_only),
  .ae_valid(ae_valid), .ae_tag(ae_tag), .ae_retry(ae_retry),
  .ds_valid(ds_valid), .ds_tag(ds_tag), .dd_valid(dd_valid), .dd_tag(dd_tag),
  .issue_en(issue_en), .pend_cnt(pend_cnt), .done_valid(done_valid),
  .done_tag(done_tag), .tag_err(tag_err), .st_flat(st_flat), .ao(ao)
);

// File: tb/tenure_tracker_tb.sv
module tenure_tracker_tb;
  localparam int TAG_W = 3;
  localparam int CNT_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             as_valid, as_addr_only, ae_valid, ae_retry, ds_valid, dd_valid;
  logic [TAG_W-1:0] as_tag, ae_tag, ds_tag, dd_tag;
  logic             issue_en, done_valid, tag_err;
  logic [CNT_W-1:0] pend_cnt;
  logic [TAG_W-1:0] done_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  tenure_tracker #(.TAG_W(TAG_W), .MAX_PEND(3)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .as_valid(as_valid), .as_tag(as_tag), .as_addr_only(as_addr_only),
    .ae_valid(ae_valid), .ae_tag(ae_tag), .ae_retry(ae_retry),
    .ds_valid(ds_valid), .ds_tag(ds_tag), .dd_valid(dd_valid), .dd_tag(dd_tag),
    .issue_en(issue_en), .pend_cnt(pend_cnt), .done_valid(done_valid),
    .done_tag(done_tag), .tag_err(tag_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    as_valid = 0; ae_valid = 0; ds_valid = 0; dd_valid = 0;
    as_addr_only = 0; ae_retry = 0;
    as_tag = '0; ae_tag = '0; ds_tag = '0; dd_tag = '0;
  endtask

  // Apply the driven inputs at the next edge, then sample 2 ns later.
  task automatic step();
    @(posedge clk);
    #2;
    idle();
  endtask

  task automatic start(int t, bit ao);
    as_valid = 1; as_tag = TAG_W'(t); as_addr_only = ao;
  endtask
  task automatic aend(int t, bit rt);
    ae_valid = 1; ae_tag = TAG_W'(t); ae_retry = rt;
  endtask
  task automatic dstart(int t);
    ds_valid = 1; ds_tag = TAG_W'(t);
  endtask
  task automatic ddone(int t);
    dd_valid = 1; dd_tag = TAG_W'(t); exp_q.push_back(t);
  endtask

  // Scoreboard monitor: each reported completion must match the oldest expected one.
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      if (exp_q.size() == 0) chk("R5 unexpected done", int'(done_tag), -1);
      else chk("R5 done_tag", int'(done_tag), exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    #1;
    chk("R1 cnt in reset", pend_cnt, 0);
    chk("R1 issue_en in reset", issue_en, 1);
    #20; @(negedge clk); rst_n = 1;
    #2;
    chk("R1 done_valid", done_valid, 0);
    chk("R1 tag_err", tag_err, 0);

    // R2: fill three data-carrying slots
    start(0, 0); step(); chk("R2 cnt 1", pend_cnt, 1);
    aend(0, 0); start(1, 0); step(); chk("R2 cnt 2", pend_cnt, 2);
    aend(1, 0); start(2, 0); step(); chk("R2 cnt 3", pend_cnt, 3);
    chk("R2 issue_en low at limit", issue_en, 0);
    aend(2, 0); step(); chk("R2 end keeps cnt", pend_cnt, 3);

    // R3: address-only accepted while full
    start(5, 1); step();
    chk("R3 no err", tag_err, 0); chk("R3 cnt", pend_cnt, 3);
    aend(5, 0); step(); chk("R3 end no err", tag_err, 0);
    start(5, 1); step(); chk("R3 tag reusable", tag_err, 0);
    aend(5, 0); step();

    // R9: data-carrying start while full is refused
    start(3, 0); step();
    chk("R9 err when full", tag_err, 1); chk("R9 cnt kept", pend_cnt, 3);

    // R4: data start reopens issue next cycle
    dstart(1); step();
    chk("R4 cnt", pend_cnt, 2); chk("R4 issue_en back", issue_en, 1);

    // R7: issue and data start together
    start(3, 0); dstart(0); step();
    chk("R7 cnt unchanged", pend_cnt, 2); chk("R7 no err", tag_err, 0);
    aend(3, 0); step();

    // R5: out-of-order completion (issued 0 then 1, completed 1 then 0)
    ddone(1); step(); chk("R5 done pulse", done_valid, 1);
    ddone(0); step(); chk("R5 second done", done_valid, 1);
    step(); chk("R5 done drops", done_valid, 0);

    // R6: retry frees slot
    start(4, 0); step(); chk("R6 cnt before retry", pend_cnt, 3);
    aend(4, 1); step(); chk("R6 cnt after retry", pend_cnt, 2);
    chk("R6 issue_en", issue_en, 1);
    start(4, 0); step(); chk("R6 reissue ok", tag_err, 0);
    chk("R6 cnt reissued", pend_cnt, 3);
    aend(4, 0); step();

    // R8: unmatched data events
    dstart(7); step(); chk("R8 ds free tag", tag_err, 1); chk("R8 cnt", pend_cnt, 3);
    dd_valid = 1; dd_tag = 3'd2; step();
    chk("R8 dd waiting tag err", tag_err, 1); chk("R8 no done", done_valid, 0);
    aend(6, 0); step(); chk("R8 ae free tag", tag_err, 1);

    // Drain
    dstart(2); step(); chk("R2 drain 2", pend_cnt, 2);
    // R9: busy tag refused even with room
    start(2, 0); step(); chk("R9 busy tag err", tag_err, 1); chk("R9 busy cnt", pend_cnt, 2);
    dstart(3); step(); dstart(4); step(); chk("R2 drained", pend_cnt, 0);
    ddone(4); step(); ddone(2); step(); ddone(3); step(); step();
    chk("R5 queue empty", exp_q.size(), 0);
    chk("R2 final issue_en", issue_en, 1);
    finish_run();
  end
endmodule